// File: doc/BRIEF.md
# Fractional Baud Generator with Majority-Vote Receive Sampling

This block times the bits of a UART link from a source clock whose frequency is not a multiple of the wanted baud rate. A 16-bit integer divisor N sets the nominal number of source ticks per bit. Each bit may be lengthened by one source tick, as chosen by one bit of an 8-bit modulation pattern. That gives a fractional average divisor. The pattern is used from its least significant bit upward and rotates after every bit. It starts again from its lowest bit whenever a bit-start event realigns the generator with an incoming start bit.

The whole block runs on one core clock. The three possible source clocks arrive as clock-enable strobes, and a 2-bit select picks one of them. A toggle register builds the bit clock from two counted half periods: a leading half of INT(N/2) plus the modulation bit, then a trailing half of INT(N/2) plus the odd remainder of N. Around the middle of each bit the received line is sampled three times, and a majority vote gives the bit value. The block only times and samples. Shifting, framing, parity and interrupts belong to its neighbours.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, bit_clk, bit_tick and rx_valid are 0 and rx_bit is 1. Until the first bit_start, no tick appears and bit_clk stays 0, whatever the enables do.
- R2: src_sel 00 takes ext_en as the source tick, 01 takes aux_en, and 10 and 11 both take sys_en. Enables that are not selected have no effect on timing.
- R3: Bit k after a bit_start lasts N + m(k) source ticks. m(k) is bit (k mod 8) of mod_pat, counted from the least significant bit, as captured at that bit_start.
- R4: In each bit, bit_clk is 0 for INT(N/2)+m(k) source ticks and then 1 for INT(N/2)+(N mod 2) ticks. bit_tick is a one-cycle pulse that coincides with the falling edge of bit_clk at the end of every bit.
- R5: The effective divisor N is {div_hi, div_lo}, with div_hi as the upper byte. A value below 3 is raised to 3.
- R6: Number the source ticks of a bit from 0. The line rxd is sampled at ticks INT(N/2)-1, INT(N/2) and INT(N/2)+1. One core cycle after the third sample, rx_bit holds the majority of the three samples and rx_valid pulses for one cycle.
- R7: A change of div_lo, div_hi or mod_pat while the block is running has no effect until the next bit_start.
- R8: bit_start wins over a tick in the same cycle and restarts timing. The cycle after it shows bit_tick 0, bit_clk 0 and rx_valid 0, even if a bit would have ended on that tick. The next bit then lasts a full period counted from the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 2 | Source tick select |
| ext_en | input | 1 | External source tick strobe |
| aux_en | input | 1 | Auxiliary source tick strobe |
| sys_en | input | 1 | Subsystem source tick strobe |
| div_lo | input | 8 | Divisor low byte |
| div_hi | input | 8 | Divisor high byte |
| mod_pat | input | 8 | Per-bit modulation pattern |
| bit_start | input | 1 | Start-of-bit realignment strobe |
| rxd | input | 1 | Received serial line |
| bit_clk | output | 1 | Bit clock, low in the leading half and high in the trailing half |
| bit_tick | output | 1 | One-cycle end-of-bit strobe |
| rx_bit | output | 1 | Majority-voted received bit |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_bit |

## Verification
Two things can land on the same core cycle. One is a bit_start. The other is the source tick that ends a bit, or the tick that takes a vote sample. The bench provokes this by raising bit_start exactly on the edge where the first bit of a period-5 run would end. It judges the outcome at the ports: that cycle must show no bit_tick and a low bit_clk, and the next tick must arrive a full period after the restart. A second clash comes from writing the divisor and pattern mid-bit. That write must not change the bit in progress or the bits after it until the next bit_start.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  typedef enum logic {
    PH_LEAD  = 1'b0,
    PH_TRAIL = 1'b1
  } half_e;

  // Raise a requested divisor to the supported floor.
  function automatic int unsigned eff_div(input int unsigned req, input int unsigned floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  // Integer half of the divisor.
  function automatic int unsigned half_of(input int unsigned n);
    return n >> 1;
  endfunction

  // Leading half period: integer half plus the modulation bit.
  function automatic int unsigned lead_len(input int unsigned n, input logic m);
    return (n >> 1) + (m ? 1 : 0);
  endfunction

  // Trailing half period: integer half plus the odd remainder.
  function automatic int unsigned trail_len(input int unsigned n);
    return (n >> 1) + (n & 1);
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/frac_baud_src_mux.sv
module frac_baud_src_mux #(
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             ext_en,
  input  logic             aux_en,
  input  logic             sys_en,
  output logic             src_en
);

  localparam logic [SEL_W-1:0] SEL_EXT = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_AUX = SEL_W'(1);

  always_comb begin
    if (sel == SEL_EXT)      src_en = ext_en;
    else if (sel == SEL_AUX) src_en = aux_en;
    else                     src_en = sys_en;
  end

endmodule

// File: rtl/frac_baud_timer.sv
module frac_baud_timer
  import frac_baud_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int MOD_W   = 8,
  parameter int MIN_DIV = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_en,
  input  logic             bit_start,
  input  logic [DIV_W-1:0] div_req,
  input  logic [MOD_W-1:0] mod_req,
  output logic             running,
  output logic             tick_adv,
  output logic             half_end,
  output logic             bit_end,
  output logic [DIV_W-1:0] div_act,
  output logic             bit_clk,
  output logic             bit_tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic [MOD_W-1:0] pat_q;
  logic [MOD_W-1:0] pat_rot;
  logic [DIV_W-1:0] div_new;
  half_e            ph_q;
  logic             run_q;
  logic             bclk_q;
  logic             tick_q;
  logic             cnt_last;

  generate
    if (MOD_W > 1) begin : g_rot
      assign pat_rot = {pat_q[0], pat_q[MOD_W-1:1]};
    end else begin : g_norot
      assign pat_rot = pat_q;
    end
  endgenerate

  assign div_new  = DIV_W'(eff_div(32'(div_req), 32'(MIN_DIV)));
  assign tick_adv = run_q & src_en & ~bit_start;
  assign cnt_last = (cnt_q == DIV_W'(1));
  assign half_end = tick_adv & cnt_last & (ph_q == PH_LEAD);
  assign bit_end  = tick_adv & cnt_last & (ph_q == PH_TRAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ph_q   <= PH_LEAD;
      cnt_q  <= '0;
      div_q  <= DIV_W'(MIN_DIV);
      pat_q  <= '0;
      bclk_q <= 1'b0;
      tick_q <= 1'b0;
    end else if (bit_start) begin
      run_q  <= 1'b1;
      ph_q   <= PH_LEAD;
      div_q  <= div_new;
      pat_q  <= mod_req;
      cnt_q  <= DIV_W'(lead_len(32'(div_new), mod_req[0]));
      bclk_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= bit_end;
      if (tick_adv) begin
        if (cnt_last) begin
          if (ph_q == PH_LEAD) begin
            ph_q   <= PH_TRAIL;
            cnt_q  <= DIV_W'(trail_len(32'(div_q)));
            bclk_q <= 1'b1;
          end else begin
            ph_q   <= PH_LEAD;
            pat_q  <= pat_rot;
            cnt_q  <= DIV_W'(lead_len(32'(div_q), pat_rot[0]));
            bclk_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - DIV_W'(1);
        end
      end
    end
  end

  assign running  = run_q;
  assign div_act  = div_q;
  assign bit_clk  = bclk_q;
  assign bit_tick = tick_q;

endmodule

// File: rtl/frac_baud_vote.sv
module frac_baud_vote
  import frac_baud_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_start,
  input  logic             tick_adv,
  input  logic             bit_end,
  input  logic [DIV_W-1:0] div_act,
  input  logic             rxd,
  output logic             samp_ev,
  output logic             rx_bit,
  output logic             rx_valid
);

  logic [DIV_W-1:0] tidx_q;
  logic [DIV_W-1:0] half;
  logic             samp_a;
  logic             samp_b;
  logic             samp_c;
  logic             s0_q;
  logic             s1_q;
  logic             bit_q;
  logic             vld_q;

  assign half   = DIV_W'(half_of(32'(div_act)));
  assign samp_a = tick_adv & (tidx_q == (half - DIV_W'(1)));
  assign samp_b = tick_adv & (tidx_q == half);
  assign samp_c = tick_adv & (tidx_q == (half + DIV_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tidx_q <= '0;
    end else if (bit_start) begin
      tidx_q <= '0;
    end else if (tick_adv) begin
      tidx_q <= bit_end ? '0 : (tidx_q + DIV_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q  <= 1'b1;
      s1_q  <= 1'b1;
      bit_q <= 1'b1;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (samp_a) s0_q <= rxd;
      if (samp_b) s1_q <= rxd;
      if (samp_c) begin
        bit_q <= maj3(s0_q, s1_q, rxd);
        vld_q <= 1'b1;
      end
    end
  end

  assign samp_ev  = samp_c;
  assign rx_bit   = bit_q;
  assign rx_valid = vld_q;

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int BYTE_W  = 8,
  parameter int MOD_W   = 8,
  parameter int SEL_W   = 2,
  parameter int MIN_DIV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic              ext_en,
  input  logic              aux_en,
  input  logic              sys_en,
  input  logic [BYTE_W-1:0] div_lo,
  input  logic [BYTE_W-1:0] div_hi,
  input  logic [MOD_W-1:0]  mod_pat,
  input  logic              bit_start,
  input  logic              rxd,
  output logic              bit_clk,
  output logic              bit_tick,
  output logic              rx_bit,
  output logic              rx_valid
);

  localparam int DIV_W = 2 * BYTE_W;

  logic             src_en_w;
  logic             run_w;
  logic             adv_w;
  logic             half_end_w;
  logic             bit_end_w;
  logic             samp_w;
  logic [DIV_W-1:0] div_w;

  frac_baud_src_mux #(.SEL_W(SEL_W)) u_mux (
    .sel    (src_sel),
    .ext_en (ext_en),
    .aux_en (aux_en),
    .sys_en (sys_en),
    .src_en (src_en_w)
  );

  frac_baud_timer #(.DIV_W(DIV_W), .MOD_W(MOD_W), .MIN_DIV(MIN_DIV)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_en    (src_en_w),
    .bit_start (bit_start),
    .div_req   ({div_hi, div_lo}),
    .mod_req   (mod_pat),
    .running   (run_w),
    .tick_adv  (adv_w),
    .half_end  (half_end_w),
    .bit_end   (bit_end_w),
    .div_act   (div_w),
    .bit_clk   (bit_clk),
    .bit_tick  (bit_tick)
  );

  frac_baud_vote #(.DIV_W(DIV_W)) u_vote (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_start (bit_start),
    .tick_adv  (adv_w),
    .bit_end   (bit_end_w),
    .div_act   (div_w),
    .rxd       (rxd),
    .samp_ev   (samp_w),
    .rx_bit    (rx_bit),
    .rx_valid  (rx_valid)
  );

endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_start,
  input logic             src_en,
  input logic             running,
  input logic             half_end,
  input logic             samp_ev,
  input logic [DIV_W-1:0] div_act,
  input logic             bit_clk,
  input logic             bit_tick,
  input logic             rx_valid
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!bit_tick && !rx_valid && !bit_clk));

  a_r2_hold_without_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_en && !bit_start) |=> (!bit_tick && $stable(bit_clk)));

  a_r4_tick_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (!bit_clk && $past(bit_clk)));

  a_r4_rise_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    half_end |=> (bit_clk && !bit_tick));

  a_r5_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (div_act >= DIV_W'(MIN_DIV)));

  a_r6_valid_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    samp_ev |=> rx_valid);

  a_r6_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r7_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_start |=> $stable(div_act));

  a_r8_restart_clean: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> (!bit_tick && !bit_clk && !rx_valid));

endmodule

bind frac_baud_gen frac_baud_chk #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_start (bit_start),
  .src_en    (src_en_w),
  .running   (run_w),
  .half_end  (half_end_w),
  .samp_ev   (samp_w),
  .div_act   (div_w),
  .bit_clk   (bit_clk),
  .bit_tick  (bit_tick),
  .rx_valid  (rx_valid)
);

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] src_sel = 2'b10;
  logic       ext_en = 1'b0, aux_en = 1'b0, sys_en = 1'b0;
  logic [7:0] div_lo = 8'd10, div_hi = 8'd0, mod_pat = 8'd0;
  logic       bit_start = 1'b0;
  logic       rxd = 1'b1;
  logic       bit_clk, bit_tick, rx_bit, rx_valid;

  frac_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_en(ext_en), .aux_en(aux_en),
    .sys_en(sys_en), .div_lo(div_lo), .div_hi(div_hi), .mod_pat(mod_pat),
    .bit_start(bit_start), .rxd(rxd), .bit_clk(bit_clk), .bit_tick(bit_tick),
    .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, srct = 0;
  int ext_k = 1, aux_k = 1, sys_k = 1;
  bit rx_on = 1'b0;
  int rx_base = 0;
  bit rx_pat [0:63];
  int tick_src [0:63];
  int rise_src [0:63];
  int ntick = 0, nrise = 0, nval = 0;
  int v0_cyc = 0;
  bit v0_bit = 1'b0;
  int start_src = 0;
  bit prev_bclk = 1'b0;
  bit done = 1'b0;

  // Bench view of the selected source tick.
  function automatic bit sel_tick();
    case (src_sel)
      2'b00:   return ext_en;
      2'b01:   return aux_en;
      default: return sys_en;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && sel_tick()) srct <= srct + 1;
  end

  always @(negedge clk) begin
    ext_en <= ((cyc + 1) % ext_k) == 0;
    aux_en <= ((cyc + 1) % aux_k) == 0;
    sys_en <= ((cyc + 1) % sys_k) == 0;
    if (rx_on && (cyc - rx_base) >= 0 && (cyc - rx_base) < 64) rxd <= rx_pat[cyc - rx_base];
    else rxd <= 1'b1;
  end

  always @(negedge clk) begin
    if (bit_tick && ntick < 64) begin tick_src[ntick] = srct; ntick = ntick + 1; end
    if (bit_clk && !prev_bclk && nrise < 64) begin rise_src[nrise] = srct; nrise = nrise + 1; end
    prev_bclk = bit_clk;
    if (rx_valid) begin
      if (nval == 0) begin v0_cyc = cyc; v0_bit = rx_bit; end
      nval = nval + 1;
    end
  end

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic int eff(input int n);
    return (n < 3) ? 3 : n;
  endfunction

  // Pulse bit_start on the next edge, then clear the event records.
  task automatic kick();
    step();
    bit_start = 1'b1;
    rx_base = cyc + 1;
    step();
    bit_start = 1'b0;
    rx_on = 1'b1;
    start_src = srct;
    ntick = 0; nrise = 0; nval = 0;
  endtask

  task automatic wait_ticks(input int n, input string tag);
    int guard = 0;
    while (ntick < n && guard < 20000) begin step(); guard++; end
    if (ntick < n) chk_eq({tag, " timeout"}, ntick, n);
  endtask

  task automatic set_div(input int n, input logic [7:0] pat);
    div_lo = n[7:0]; div_hi = n[15:8]; mod_pat = pat;
  endtask

  task automatic t_reset();
    chk_eq("R1 bit_clk after reset", bit_clk, 0);
    chk_eq("R1 bit_tick after reset", bit_tick, 0);
    chk_eq("R1 rx_valid after reset", rx_valid, 0);
    chk_eq("R1 rx_bit after reset", rx_bit, 1);
    ntick = 0; nrise = 0; nval = 0;
    repeat (30) step();
    chk_eq("R1 idle ticks", ntick, 0);
    chk_eq("R1 idle rises", nrise, 0);
    chk_eq("R1 idle valid", nval, 0);
  endtask

  // Check bits 0..nb-1 of a run: length and leading-half length.
  task automatic t_periods(input int n, input logic [7:0] pat, input int nb, input string tag);
    set_div(n, pat);
    kick();
    wait_ticks(nb, tag);
    for (int k = 0; k < nb && k < ntick; k++) begin
      int base = (k == 0) ? start_src : tick_src[k-1];
      int m = pat[k % 8];
      chk_eq($sformatf("R3 %s bit %0d length", tag, k), tick_src[k] - base, eff(n) + m);
      if (k < nrise)
        chk_eq($sformatf("R4 %s bit %0d lead half", tag, k), rise_src[k] - base, eff(n) / 2 + m);
    end
  endtask

  task automatic t_clamp();
    t_periods(1, 8'h00, 2, "R5 div1");
    t_periods(0, 8'h00, 2, "R5 div0");
    t_periods(2, 8'h00, 2, "R5 div2");
    t_periods(256, 8'h00, 1, "R5 hibyte");
  endtask

  task automatic t_vote(input int n, input bit a, input bit b, input bit c);
    int h = n / 2;
    bit exp_b = (a & b) | (a & c) | (b & c);
    for (int i = 0; i < 64; i++) rx_pat[i] = ~exp_b;
    rx_pat[h-1] = a; rx_pat[h] = b; rx_pat[h+1] = c;
    set_div(n, 8'h00);
    kick();
    repeat (n + 2) step();
    chk_eq($sformatf("R6 vote %0d%0d%0d N=%0d bit", a, b, c, n), v0_bit, exp_b);
    chk_eq($sformatf("R6 vote %0d%0d%0d N=%0d cycle", a, b, c, n), v0_cyc, rx_base + h + 2);
    rx_on = 1'b0;
  endtask

  task automatic t_hold();
    set_div(6, 8'h00);
    kick();
    wait_ticks(1, "R7 first");
    set_div(12, 8'hFF);
    wait_ticks(3, "R7 held");
    chk_eq("R7 bit 1 keeps old divisor", tick_src[1] - tick_src[0], 6);
    chk_eq("R7 bit 2 keeps old divisor", tick_src[2] - tick_src[1], 6);
    kick();
    wait_ticks(1, "R7 new");
    chk_eq("R7 new divisor after start", tick_src[0] - start_src, 13);
  endtask

  task automatic t_clash();
    set_div(5, 8'h00);
    kick();
    repeat (3) step();
    kick();
    chk_eq("R8 no tick on restart edge", bit_tick, 0);
    chk_eq("R8 bit_clk low on restart", bit_clk, 0);
    wait_ticks(1, "R8 after");
    chk_eq("R8 full period after restart", tick_src[0] - start_src, 5);
  endtask

  task automatic t_source(input logic [1:0] sel);
    src_sel = sel;
    ext_k = (sel == 2'b00) ? 3 : 1;
    aux_k = (sel == 2'b01) ? 3 : 1;
    sys_k = (sel[1]) ? 3 : 1;
    repeat (2) step();
    set_div(4, 8'h00);
    kick();
    wait_ticks(2, "R2 src");
    chk_eq($sformatf("R2 sel %0d bit 0", sel), tick_src[0] - start_src, 4);
    chk_eq($sformatf("R2 sel %0d bit 1", sel), tick_src[1] - tick_src[0], 4);
    ext_k = 1; aux_k = 1; sys_k = 1; src_sel = 2'b10;
    repeat (2) step();
  endtask

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_periods(10, 8'h00, 3, "even");
    t_periods(7, 8'h00, 3, "odd");
    t_periods(7, 8'h01, 2, "oddmod");
    t_periods(8, 8'hA6, 10, "pattern");
    t_periods(3, 8'h5A, 9, "fastest");
    t_clamp();
    t_vote(9, 0, 0, 0); t_vote(9, 0, 0, 1); t_vote(9, 0, 1, 0); t_vote(9, 1, 0, 0);
    t_vote(9, 0, 1, 1); t_vote(9, 1, 1, 0); t_vote(9, 1, 0, 1); t_vote(9, 1, 1, 1);
    t_vote(3, 1, 0, 1); t_vote(4, 0, 1, 0);
    t_hold();
    t_clash();
    t_source(2'b00); t_source(2'b01); t_source(2'b10); t_source(2'b11);
    finish_run();
  end

endmodule